// File: doc/BRIEF.md
# Pipelined Fixed-Point Base-2 Logarithm Unit

This block takes an unsigned fixed-point number with a configurable integer field and fraction field and returns its base-2 logarithm as a fixed-point result. The result carries a small integer field, the position of the leading one in the input's integer field, and a wide fraction field read from a table of log2 values over [1,2). The table is addressed by the bits that sit directly below the leading one once the input has been normalised. Because the leading one is implied, it is never used as part of the table address.

The unit accepts one sample per clock and never stalls: its ready output is tied high. Every result appears a fixed number of cycles after its input. That is three cycles, or four when the optional output register is enabled. A sample whose integer field is zero (a value below one) has no defined logarithm. It is returned with its valid strobe, an error flag and an all-zero result word. The table contents are computed at elaboration with integer arithmetic only.

Top module: `log2_pipe`

## Requirements
- R1: `in_ready` is 1 in every cycle, both during reset and after it.
- R2: A sample taken with `in_valid`=1 gives exactly one `out_valid`=1 cycle. It appears 3 clock edges after capture when `OUT_REG`=0 and 4 edges after capture when `OUT_REG`=1, and samples stay in order.
- R3: For a valid input with a non-zero integer field (`in_data[INT_W+FRAC_W-1:FRAC_W]`), the top `$clog2(INT_W)` bits of `out_data` equal the bit position of the highest set bit in that field.
- R4: The low `INT_W+FRAC_W-$clog2(INT_W)` bits of `out_data` (F bits) match the fractional part of log2(input) times 2^F. The allowed error is at most 2^F·log2(1+2^-LUT_P) plus 2 LSB.
- R5: When the input is an exact power of two of at least one, the fraction bits of `out_data` are zero.
- R6: A valid input whose integer field is zero returns `out_err`=1 together with `out_valid`=1 and `out_data`=0. `out_err` is never 1 while `out_valid` is 0.
- R7: The error flag belongs to one sample only. A valid sample that is at least one gets `out_err`=0 even when its neighbours on either side are below one.
- R8: While `rst` is 1, `out_valid` and `out_err` read 0 from the next edge on. Samples held in the pipeline when reset arrives produce no output afterwards.
- R9: A cycle with `in_valid`=0 produces a cycle with `out_valid`=0 at the matching output slot, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | Always 1; one sample accepted per clock |
| in_data | input | INT_W+FRAC_W | Unsigned fixed-point operand; integer field on top |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Sample was below one; result word forced to zero |
| out_data | output | INT_W+FRAC_W | Result: leading-one position on top, table fraction below |

## Verification
Two things can happen in the same cycle: an error-flagged sample can sit in one pipeline stage while an ordinary result sits in the stage next to it. Both share the stage registers that carry the flag and the data. The bench provokes this by feeding values below one and full-scale values on alternate cycles, and values below one between ordinary values in the vector walk. Each output cycle is judged against the bench's own record of which input fed that slot, three or four edges earlier. The error flag, the zero result word and the integer field must all belong to that sample and not to its neighbour.

// File: rtl/log2_pkg.sv
package log2_pkg;

    // Returns round(log2(1 + idx/2^prec) * 2^frac_bits) using only integer
    // arithmetic: repeated squaring of a Q30 mantissa yields one result bit
    // per step; one extra bit is produced for the final rounding.
    function automatic logic [31:0] log2_frac_entry(input int unsigned idx,
                                                    input int unsigned frac_bits,
                                                    input int unsigned prec);
        logic [63:0] y;
        logic [31:0] acc;
        y   = (64'd1 << 30) + (64'(idx) << (30 - prec));
        acc = '0;
        for (int unsigned k = 0; k < frac_bits + 1; k++) begin
            y   = (y * y) >> 30;
            acc = acc << 1;
            if (y >= (64'd2 << 30)) begin
                y   = y >> 1;
                acc = acc | 32'd1;
            end
        end
        return (acc + 32'd1) >> 1;
    endfunction

endpackage

// File: rtl/log2_lead_enc.sv
module log2_lead_enc #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] pos,
    output logic          none
);
    // Highest set bit wins: later loop iterations overwrite earlier ones.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = IW'(i);
        end
        none = ~|vec;
    end
endmodule

// File: rtl/log2_mant_window.sv
module log2_mant_window #(
    parameter int XW = 23,
    parameter int P  = 6,
    parameter int SW = 4
) (
    input  logic [XW-1:0] mant,
    input  logic [SW-1:0] shamt,
    output logic [P-1:0]  addr
);
    // Left-shift normaliser that only builds the P bits under the implied
    // leading one; zero padding covers shifts that run past the LSB.
    localparam int EXT_W = XW + P;
    localparam int TOP   = EXT_W - 1;

    logic [EXT_W-1:0] ext;

    assign ext  = {mant, {P{1'b0}}};
    assign addr = ext[TOP - int'(shamt) -: P];
endmodule

// File: rtl/log2_frac_rom.sv
module log2_frac_rom #(
    parameter int FW = 20,
    parameter int P  = 6
) (
    input  logic [P-1:0]  addr,
    output logic [FW-1:0] val
);
    localparam int DEPTH = 1 << P;

    logic [FW-1:0] tab [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [31:0] ENTRY = log2_pkg::log2_frac_entry(g, FW, P);
        assign tab[g] = ENTRY[FW-1:0];
    end

    assign val = tab[addr];
endmodule

// File: rtl/log2_pipe.sv
module log2_pipe #(
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 8,
    parameter int LUT_P   = 6,
    parameter int OUT_REG = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [INT_W+FRAC_W-1:0] in_data,
    output logic                    out_valid,
    output logic                    out_err,
    output logic [INT_W+FRAC_W-1:0] out_data
);
    localparam int IN_W = INT_W + FRAC_W;
    localparam int OI_W = $clog2(INT_W);
    localparam int OF_W = IN_W - OI_W;
    localparam int XW   = IN_W - 1;

    assign in_ready = 1'b1;

    // ---------------- stage 1: capture and leading-one search -------------
    logic [OI_W-1:0] enc_pos;
    logic            enc_none;

    log2_lead_enc #(.W(INT_W), .IW(OI_W)) u_enc (
        .vec  (in_data[IN_W-1:FRAC_W]),
        .pos  (enc_pos),
        .none (enc_none)
    );

    logic            s1_v, s1_e;
    logic [OI_W-1:0] s1_pos;
    logic [XW-1:0]   s1_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_e <= 1'b0;
        end else begin
            s1_v <= in_valid;
            s1_e <= in_valid & enc_none;
        end
    end

    always_ff @(posedge clk) begin
        s1_pos <= enc_pos;
        s1_x   <= in_data[XW-1:0];
    end

    // ---------------- stage 2: normalise, keep table address --------------
    logic [OI_W-1:0]  shamt;
    logic [LUT_P-1:0] win_addr;

    assign shamt = OI_W'(INT_W - 1) - s1_pos;

    log2_mant_window #(.XW(XW), .P(LUT_P), .SW(OI_W)) u_win (
        .mant  (s1_x),
        .shamt (shamt),
        .addr  (win_addr)
    );

    logic             s2_v, s2_e;
    logic [OI_W-1:0]  s2_ip;
    logic [LUT_P-1:0] s2_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v <= 1'b0;
            s2_e <= 1'b0;
        end else begin
            s2_v <= s1_v;
            s2_e <= s1_e;
        end
    end

    always_ff @(posedge clk) begin
        s2_ip   <= s1_pos;
        s2_addr <= win_addr;
    end

    // ---------------- stage 3: table read and result assembly -------------
    logic [OF_W-1:0] rom_val;

    log2_frac_rom #(.FW(OF_W), .P(LUT_P)) u_rom (
        .addr (s2_addr),
        .val  (rom_val)
    );

    logic            s3_v, s3_e;
    logic [IN_W-1:0] s3_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_v <= 1'b0;
            s3_e <= 1'b0;
        end else begin
            s3_v <= s2_v;
            s3_e <= s2_e;
        end
    end

    always_ff @(posedge clk) begin
        s3_d <= s2_e ? '0 : {s2_ip, rom_val};
    end

    // ---------------- optional output register ----------------------------
    if (OUT_REG != 0) begin : g_oreg
        logic            o_v, o_e;
        logic [IN_W-1:0] o_d;

        always_ff @(posedge clk) begin
            if (rst) begin
                o_v <= 1'b0;
                o_e <= 1'b0;
            end else begin
                o_v <= s3_v;
                o_e <= s3_e;
            end
        end

        always_ff @(posedge clk) begin
            o_d <= s3_d;
        end

        assign out_valid = o_v;
        assign out_err   = o_e;
        assign out_data  = o_d;
    end else begin : g_direct
        assign out_valid = s3_v;
        assign out_err   = s3_e;
        assign out_data  = s3_d;
    end
endmodule

// File: rtl/log2_pipe_chk.sv
module log2_pipe_chk #(
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 8,
    parameter int OUT_REG = 0
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [INT_W+FRAC_W-1:0] in_data,
    input logic                    out_valid,
    input logic                    out_err,
    input logic [INT_W+FRAC_W-1:0] out_data
);
    localparam int IN_W = INT_W + FRAC_W;
    localparam int OF_W = IN_W - $clog2(INT_W);
    localparam int LAT  = 3 + ((OUT_REG != 0) ? 1 : 0);

    // Independent model of which output slot each input lands in.
    logic [LAT-1:0] vq, eq, pq;

    always_ff @(posedge clk) begin
        if (rst) begin
            vq <= '0;
            eq <= '0;
            pq <= '0;
        end else begin
            vq <= {vq[LAT-2:0], in_valid};
            eq <= {eq[LAT-2:0], (in_data[IN_W-1:FRAC_W] == '0)};
            pq <= {pq[LAT-2:0], ($countones(in_data) == 1)};
        end
    end

    p_ready_high_r1: assert property (@(posedge clk) disable iff (rst)
        in_ready == 1'b1);

    p_fixed_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == vq[LAT-1]);

    p_err_matches_sample_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_err == eq[LAT-1]));

    p_err_zero_word_r6: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_valid && out_data == '0));

    p_pow2_no_frac_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pq[LAT-1]) |-> (out_data[OF_W-1:0] == '0));
endmodule

bind log2_pipe log2_pipe_chk #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_data  (out_data)
);

// File: tb/log2_pipe_bench.sv
module log2_pipe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 8;
    localparam int LUT_P  = 6;
    localparam int IN_W   = INT_W + FRAC_W;
    localparam int OI_W   = $clog2(INT_W);
    localparam int OF_W   = IN_W - OI_W;
    localparam int NVEC   = 20;

    // {valid, data}
    localparam logic [IN_W:0] VEC [NVEC] = '{
        {1'b1, 24'h000100}, {1'b1, 24'h000180}, {1'b1, 24'h000000},
        {1'b1, 24'h000200}, {1'b0, 24'h123456}, {1'b1, 24'hFFFFFF},
        {1'b1, 24'h0000FF}, {1'b1, 24'h800000}, {1'b1, 24'h000300},
        {1'b1, 24'h00017F}, {1'b0, 24'h000000}, {1'b1, 24'h7FFF00},
        {1'b1, 24'h123456}, {1'b1, 24'h010000}, {1'b1, 24'h0001FF},
        {1'b1, 24'h000101}, {1'b1, 24'h000080}, {1'b1, 24'h400080},
        {1'b1, 24'h00FFC0}, {1'b1, 24'h000001}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [IN_W-1:0] in_data;
    logic a_ready, a_valid, a_err;
    logic b_ready, b_valid, b_err;
    logic [IN_W-1:0] a_data, b_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    logic            hist_v [1024];
    logic [IN_W-1:0] hist_d [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    log2_pipe #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LUT_P(LUT_P), .OUT_REG(0)) u_log2_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(a_ready),
        .in_data(in_data), .out_valid(a_valid), .out_err(a_err), .out_data(a_data)
    );

    log2_pipe #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LUT_P(LUT_P), .OUT_REG(1)) u_log2_pipe_oreg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(b_ready),
        .in_data(in_data), .out_valid(b_valid), .out_err(b_err), .out_data(b_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lead_pos(input logic [INT_W-1:0] f);
        int p = -1;
        for (int i = 0; i < INT_W; i++) if (f[i]) p = i;
        return p;
    endfunction

    task automatic judge(input logic ov, input logic oe, input logic [IN_W-1:0] od,
                         input logic sv, input logic [IN_W-1:0] sd, input string who);
        logic [INT_W-1:0] ip;
        int   msb;
        real  x, ref_f, tol, diff;
        if (!sv) begin
            check(ov == 1'b0, {"R9 idle slot ", who}, ov, 0);
            check(oe == 1'b0, {"R6 no err when idle ", who}, oe, 0);
        end else begin
            check(ov == 1'b1, {"R2 latency valid ", who}, ov, 1);
            ip = sd[IN_W-1:FRAC_W];
            if (ip == '0) begin
                check(oe == 1'b1, {"R6 below one err ", who}, oe, 1);
                check(od == '0, {"R6 zero word ", who}, od, 0);
            end else begin
                msb = lead_pos(ip);
                check(oe == 1'b0, {"R7 err isolated ", who}, oe, 0);
                check(int'(od[IN_W-1:OF_W]) == msb, {"R3 integer part ", who},
                      od[IN_W-1:OF_W], msb);
                x     = real'(sd) / real'(1 << FRAC_W);
                ref_f = ($ln(x) / $ln(2.0) - real'(msb)) * real'(1 << OF_W);
                tol   = real'(1 << OF_W) * $ln(1.0 + 1.0 / real'(1 << LUT_P)) / $ln(2.0) + 2.0;
                diff  = real'(od[OF_W-1:0]) - ref_f;
                if (diff < 0.0) diff = -diff;
                check(diff <= tol, {"R4 fraction ", who}, od[OF_W-1:0], longint'(ref_f));
                if ($countones(sd) == 1)
                    check(od[OF_W-1:0] == '0, {"R5 power of two ", who}, od[OF_W-1:0], 0);
            end
        end
    endtask

    // Called at a falling edge: judge both outputs, then drive this cycle.
    task automatic step(input logic v, input logic [IN_W-1:0] d);
        judge(a_valid, a_err, a_data,
              (cyc >= 3) ? hist_v[cyc-3] : 1'b0, (cyc >= 3) ? hist_d[cyc-3] : '0, "oreg0");
        judge(b_valid, b_err, b_data,
              (cyc >= 4) ? hist_v[cyc-4] : 1'b0, (cyc >= 4) ? hist_d[cyc-4] : '0, "oreg1");
        check(a_ready && b_ready, "R1 ready", a_ready & b_ready, 1);
        in_valid    = v;
        in_data     = d;
        hist_v[cyc] = v;
        hist_d[cyc] = d;
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst      = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!a_valid && !b_valid, "R8 valid low in reset", a_valid | b_valid, 0);
            check(!a_err && !b_err, "R8 err low in reset", a_err | b_err, 0);
            check(a_ready && b_ready, "R1 ready in reset", a_ready & b_ready, 1);
        end
        rst = 1'b0;
        for (int i = 0; i < 1024; i++) hist_v[i] = 1'b0;
        cyc = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b0;
        in_data  = '0;
        @(negedge clk);
        do_reset(4);

        // Vector walk: mixed ordinary, below-one and idle slots (R2-R7, R9).
        for (int i = 0; i < NVEC; i++) step(VEC[i][IN_W], VEC[i][IN_W-1:0]);
        for (int i = 0; i < 5; i++) step(1'b0, 24'hABCDEF);

        // Error and ordinary samples in adjacent stages every cycle (R7, R6).
        for (int i = 0; i < 10; i++) step(1'b1, (i % 2 == 0) ? 24'h000000 : 24'hFFFFFF);
        for (int i = 0; i < 5; i++) step(1'b0, '0);

        // Leading-one sweep across the integer field (R3, R5).
        for (int i = 0; i < INT_W; i++) step(1'b1, IN_W'(1) << (FRAC_W + i));
        for (int i = 0; i < 5; i++) step(1'b0, '0);

        // Reset with a full pipeline: nothing may emerge afterwards (R8).
        for (int i = 0; i < 4; i++) step(1'b1, 24'h003456 + IN_W'(i));
        do_reset(1);
        for (int i = 0; i < 6; i++) step(1'b0, 24'h000100);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule